// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit timer peripheral with a small register interface. A prescale stage divides the clock, and each prescale rollover advances a 32-bit count. In counter mode the count advances on edges of an external input instead. The input is first synchronized. The prescale stage is not used in counter mode.

Four compare channels each hold a 32-bit value. A channel fires on the count tick at which the count equals its value. Each channel can then do any mix of three things: latch an interrupt flag, send the count back to zero, or freeze the timer. Independently of those, each channel drives one output bit, which it can leave alone, clear, set or invert. Software clears an interrupt flag by writing a one to it. The OR of all flags forms a single interrupt request line.

Software reaches the block through a single-cycle write strobe with a byte address. Reads are combinational.

Top module: `match_timer`

## Requirements
- R1: In timer mode, the prescale value PC counts up once per clock while enabled. On the clock where PC equals the prescale limit PR, PC returns to 0 and the count TC goes up by one. After N enabled clocks from a cleared state, TC = N / (PR+1) and PC = N mod (PR+1).
- R2: Bit 0 of the control register (offset 0x04) enables counting. While bit 1 is one, TC and PC are held at zero, and they stay there until software clears bit 1.
- R3: The mode register (offset 0x70, bits [1:0]) selects the count source. 00 is timer mode. 01 counts rising edges of `ext_in`, 10 counts falling edges and 11 counts both. `ext_in` passes through two synchronizing flops before edge detection.
- R4: For channel n, bit 3n of the action register (offset 0x14) enables the interrupt action. When a match occurs with this bit set, flag n (bit n of offset 0x00) becomes 1.
- R5: For channel n, bit 3n+1 of the action register enables the reset action. When a match occurs with this bit set, TC reads 0 after that tick instead of the compare value plus one.
- R6: For channel n, bit 3n+2 of the action register enables the stop action. When a match occurs with this bit set, TC holds its value, PC returns to 0 and the enable bit is cleared.
- R7: The output register (offset 0x3C) holds the output bits in [3:0]. It holds a 2-bit code for channel n in bits [5+2n:4+2n]. On a match the code acts as follows: 00 leaves the bit as it is, 01 clears it, 10 sets it and 11 inverts it. The bits appear on `match_out`.
- R8: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged. `irq` is high exactly when any flag is set.
- R9: When a match sets a flag in the same cycle that software clears it, the flag stays set.
- R10: The register offsets are: flags 0x00, control 0x04, TC 0x08, PR 0x0C, PC 0x10, actions 0x14, compare values 0x18/0x1C/0x20/0x24, outputs 0x3C and mode 0x70. After reset, all registers, `irq` and `match_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_in | input | 1 | External count input, asynchronous |
| match_out | output | 4 | Channel output bits |
| irq | output | 1 | OR of the interrupt flags |

## Verification
Two functions can land on a flag in the same cycle: a match that sets it and a software write that clears it. The bench provokes this by counting clocks from the enable write, so that a clear write reaches the register on exactly the tick where the count equals the compare value. It then expects the flag to read one. A second clear, issued when no match is due, must bring the flag back to zero. The same clock-counting approach lands the reset and stop actions on known ticks, so the expected count values can be computed from the requirements alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] OFF_FLAG = 8'h00;
  localparam logic [AW-1:0] OFF_CTRL = 8'h04;
  localparam logic [AW-1:0] OFF_TC   = 8'h08;
  localparam logic [AW-1:0] OFF_PR   = 8'h0C;
  localparam logic [AW-1:0] OFF_PC   = 8'h10;
  localparam logic [AW-1:0] OFF_ACT  = 8'h14;
  localparam logic [AW-1:0] OFF_CMP0 = 8'h18;
  localparam logic [AW-1:0] OFF_OUT  = 8'h3C;
  localparam logic [AW-1:0] OFF_MODE = 8'h70;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_act_e;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'b00,
    SRC_RISE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_BOTH = 2'b11
  } src_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [1:0]   src,
  input  logic         ext_in,
  input  logic [W-1:0] pr,
  input  logic         hit_rst,
  input  logic         hit_stop,
  output logic [W-1:0] tc,
  output logic [W-1:0] pc,
  output logic         tick
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall, edge_ok, pre_wrap;
  logic [W-1:0] tc_d, pc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    case (src_e'(src))
      SRC_RISE: edge_ok = rise;
      SRC_FALL: edge_ok = fall;
      SRC_BOTH: edge_ok = rise | fall;
      default:  edge_ok = 1'b0;
    endcase
  end

  assign pre_wrap = (pc >= pr);
  assign tick = en & ~clr & ((src == SRC_CLK) ? pre_wrap : edge_ok);

  always_comb begin
    tc_d = tc;
    pc_d = pc;
    if (clr) begin
      tc_d = '0;
      pc_d = '0;
    end else if (en) begin
      if (src != SRC_CLK) pc_d = '0;
      else if (pre_wrap)  pc_d = '0;
      else                pc_d = pc + 1'b1;
      if (tick) begin
        if (hit_rst)       tc_d = '0;
        else if (!hit_stop) tc_d = tc + 1'b1;
      end
      if (tick && hit_stop) pc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0;
      pc <= '0;
    end else begin
      tc <= tc_d;
      pc <= pc_d;
    end
  end

  // R2: control reset holds both counters at zero
  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc == '0 && pc == '0));
  // R1: a plain tick advances the count by one
  a_r1_tc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit_rst && !hit_stop) |=> (tc == $past(tc) + 1'b1));
  // R5: reset action returns the count to zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit_rst) |=> (tc == '0));
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] tc,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   act,
  input  logic         sw_we,
  input  logic         sw_val,
  output logic         hit,
  output logic         pin_q
);
  logic pin_d;

  assign hit = tick & (tc == cmp);

  always_comb begin
    pin_d = pin_q;
    if (hit) begin
      case (pin_act_e'(act))
        PIN_LOW:  pin_d = 1'b0;
        PIN_HIGH: pin_d = 1'b1;
        PIN_FLIP: pin_d = ~pin_q;
        default:  pin_d = pin_q;
      endcase
    end else if (sw_we) begin
      pin_d = sw_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  // R7: invert code flips the pin on a match
  a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == PIN_FLIP) |=> (pin_q != $past(pin_q)));
  // R7: keep code leaves the pin unchanged on a match
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == PIN_KEEP) |=> $stable(pin_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_d;

  assign flags_d = (flags & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  assign irq = |flags;

  // R9: a match wins over a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
  // R8: a clear with no match removes the flag
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int NCH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_in,
  output logic [NCH-1:0] match_out,
  output logic          irq
);
  localparam int ACT_W = 3 * NCH;
  localparam int PIN_W = 2 * NCH;
  localparam int OUT_W = NCH + PIN_W;

  logic              ctl_en_q, ctl_clr_q, ctl_en_d, ctl_clr_d;
  logic [DW-1:0]     pr_q;
  logic [ACT_W-1:0]  act_q;
  logic [PIN_W-1:0]  pin_act_q;
  logic [1:0]        src_q;
  logic [DW-1:0]     cmp_q [NCH];

  logic [DW-1:0]     tc, pc;
  logic              tick;
  logic [NCH-1:0]    hit, int_en, rst_en, stop_en, flags, flag_clr;
  logic              hit_rst, hit_stop;
  logic              wr_ctrl, wr_pr, wr_act, wr_out, wr_mode, wr_flag;
  logic [NCH-1:0]    wr_cmp;

  assign wr_flag = bus_we && bus_addr == OFF_FLAG;
  assign wr_ctrl = bus_we && bus_addr == OFF_CTRL;
  assign wr_pr   = bus_we && bus_addr == OFF_PR;
  assign wr_act  = bus_we && bus_addr == OFF_ACT;
  assign wr_out  = bus_we && bus_addr == OFF_OUT;
  assign wr_mode = bus_we && bus_addr == OFF_MODE;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign wr_cmp[n]  = bus_we && bus_addr == AW'(OFF_CMP0 + 4 * n);
    assign int_en[n]  = act_q[3*n];
    assign rst_en[n]  = act_q[3*n+1];
    assign stop_en[n] = act_q[3*n+2];
  end

  assign hit_rst  = |(hit & rst_en);
  assign hit_stop = |(hit & stop_en);

  // control register next state: stop action overrides software enable
  always_comb begin
    ctl_en_d  = ctl_en_q;
    ctl_clr_d = ctl_clr_q;
    if (wr_ctrl) begin
      ctl_en_d  = bus_wdata[0];
      ctl_clr_d = bus_wdata[1];
    end
    if (hit_stop) ctl_en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en_q  <= 1'b0;
      ctl_clr_q <= 1'b0;
    end else begin
      ctl_en_q  <= ctl_en_d;
      ctl_clr_q <= ctl_clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q      <= '0;
      act_q     <= '0;
      pin_act_q <= '0;
      src_q     <= '0;
    end else begin
      if (wr_pr)   pr_q      <= bus_wdata;
      if (wr_act)  act_q     <= bus_wdata[ACT_W-1:0];
      if (wr_out)  pin_act_q <= bus_wdata[OUT_W-1:NCH];
      if (wr_mode) src_q     <= bus_wdata[1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cmp_q[n] <= '0;
      else if (wr_cmp[n])  cmp_q[n] <= bus_wdata;
    end

    tmr_match_chan #(.W(DW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .tc     (tc),
      .cmp    (cmp_q[n]),
      .act    (pin_act_q[2*n+1:2*n]),
      .sw_we  (wr_out),
      .sw_val (bus_wdata[n]),
      .hit    (hit[n]),
      .pin_q  (match_out[n])
    );
  end

  tmr_count #(.W(DW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en_q),
    .clr      (ctl_clr_q),
    .src      (src_q),
    .ext_in   (ext_in),
    .pr       (pr_q),
    .hit_rst  (hit_rst),
    .hit_stop (hit_stop),
    .tc       (tc),
    .pc       (pc),
    .tick     (tick)
  );

  assign flag_clr = wr_flag ? bus_wdata[NCH-1:0] : '0;

  tmr_irq #(.N(NCH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit & int_en),
    .clr   (flag_clr),
    .flags (flags),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_FLAG: bus_rdata[NCH-1:0]   = flags;
      OFF_CTRL: bus_rdata[1:0]       = {ctl_clr_q, ctl_en_q};
      OFF_TC:   bus_rdata            = tc;
      OFF_PR:   bus_rdata            = pr_q;
      OFF_PC:   bus_rdata            = pc;
      OFF_ACT:  bus_rdata[ACT_W-1:0] = act_q;
      OFF_OUT:  bus_rdata[OUT_W-1:0] = {pin_act_q, match_out};
      OFF_MODE: bus_rdata[1:0]       = src_q;
      default: begin
        for (int n = 0; n < NCH; n++)
          if (bus_addr == AW'(OFF_CMP0 + 4 * n)) bus_rdata = cmp_q[n];
      end
    endcase
  end

  // R6: a stop match drops the enable bit
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stop |=> !ctl_en_q);
  // R6: count is frozen while disabled and not cleared
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en_q && !ctl_clr_q) |=> $stable(tc));
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ext_in;
  logic [3:0]  match_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
    .match_out(match_out), .irq(irq)
  );

  // {prescale limit, enabled clocks, expected TC, expected PC}
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{0, 10, 10, 0},
    '{1,  9,  4, 1},
    '{3, 17,  4, 1},
    '{4, 25,  5, 0},
    '{6, 20,  2, 6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_in = 1'b1; repeat (4) @(negedge clk);
      ext_in = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ext_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    rd(8'h08, d); check("R10 tc reset", d, 0);
    rd(8'h00, d); check("R10 flags reset", d, 0);
    rd(8'h04, d); check("R10 ctrl reset", d, 0);
    check("R10 irq reset", {31'b0, irq}, 0);
    check("R10 match_out reset", {28'b0, match_out}, 0);

    // R1: prescale table
    for (int v = 0; v < NV; v++) begin
      wr(8'h04, 32'h2);
      wr(8'h0C, VEC[v][0]);
      wr(8'h04, 32'h1);
      repeat (VEC[v][1] - 1) @(negedge clk);
      wr(8'h04, 32'h0);
      rd(8'h08, d); check("R1 tc", d, VEC[v][2]);
      rd(8'h10, d); check("R1 pc", d, VEC[v][3]);
    end

    // R4 R5: interrupt plus reset on channel 0, compare 4
    wr(8'h04, 32'h2);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'd4);
    wr(8'h14, 32'h3);
    wr(8'h04, 32'h1);
    repeat (11) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h08, d); check("R5 tc wraps at compare", d, 2);
    rd(8'h00, d); check("R4 flag set", d, 1);
    check("R8 irq high", {31'b0, irq}, 1);

    // R8: write zero has no effect, write one clears
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R8 zero write ignored", d, 1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); check("R8 one write clears", d, 0);
    check("R8 irq low", {31'b0, irq}, 0);

    // R9: clear lands on the matching tick
    wr(8'h04, 32'h2);
    wr(8'h14, 32'h1);
    wr(8'h18, 32'd6);
    wr(8'h04, 32'h1);
    repeat (6) @(negedge clk);
    wr(8'h00, 32'h1);
    rd(8'h00, d); check("R9 set beats clear", d, 1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); check("R9 later clear", d, 0);
    wr(8'h04, 32'h0);

    // R6: stop on channel 1 at compare 3
    wr(8'h04, 32'h2);
    wr(8'h14, 32'h20);
    wr(8'h1C, 32'd3);
    wr(8'h04, 32'h1);
    repeat (10) @(negedge clk);
    rd(8'h08, d); check("R6 tc held", d, 3);
    rd(8'h04, d); check("R6 enable cleared", d, 0);
    rd(8'h10, d); check("R6 pc zero", d, 0);

    // R7: flip, high, low, keep on channels 0..3
    wr(8'h04, 32'h2);
    wr(8'h18, 32'd1);
    wr(8'h1C, 32'd2);
    wr(8'h20, 32'd3);
    wr(8'h24, 32'd4);
    wr(8'h14, 32'h400);
    wr(8'h3C, 32'h1BC);
    wr(8'h04, 32'h1);
    repeat (4) @(negedge clk);
    wr(8'h04, 32'h0);
    check("R7 outputs first pass", {28'b0, match_out}, 32'hB);
    rd(8'h3C, d); check("R7 output register", d, 32'h1BB);
    wr(8'h04, 32'h1);
    repeat (4) @(negedge clk);
    wr(8'h04, 32'h0);
    check("R7 outputs second pass", {28'b0, match_out}, 32'hA);
    wr(8'h3C, 32'h0);
    wr(8'h14, 32'h0);

    // R3: counter modes
    wr(8'h04, 32'h2); wr(8'h70, 32'h1); wr(8'h04, 32'h1);
    pulses(3);
    rd(8'h08, d); check("R3 rising edges", d, 3);
    wr(8'h04, 32'h2); wr(8'h70, 32'h2); wr(8'h04, 32'h1);
    pulses(3);
    rd(8'h08, d); check("R3 falling edges", d, 3);
    wr(8'h04, 32'h2); wr(8'h70, 32'h3); wr(8'h04, 32'h1);
    pulses(3);
    rd(8'h08, d); check("R3 both edges", d, 6);
    wr(8'h04, 32'h0); wr(8'h70, 32'h0);

    // R2: reset bit holds counters while enabled
    wr(8'h04, 32'h3);
    repeat (5) @(negedge clk);
    rd(8'h08, d); check("R2 tc held zero", d, 0);
    rd(8'h10, d); check("R2 pc held zero", d, 0);
    wr(8'h04, 32'h1);
    repeat (2) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h08, d); check("R2 counts after release", d, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule